// File: doc/BRIEF.md
# Two-Word Round-Key Expansion Unit

This unit produces the 64-bit round keys of a 128-bit-block, 128-bit-key lightweight Feistel cipher, one key for each advance strobe, so that a round engine can consume them in step without a stored key table. A 128-bit master key is loaded with a strobe. The unit keeps only two key words and a position in a 62-bit round-constant sequence. From these it computes the next key word with a rotate/XOR recurrence.

The direction is chosen at load time. For encryption the keys come out in ascending order k0, k1, ..., k67, starting on the cycle after the load. For decryption the unit first winds itself forward, without outside help, until it holds the last two keys. It then hands them out in descending order k67, k66, ..., k0. Each descending key is recovered by inverting the recurrence, so the unit never stores all 68 keys.

Top module: `lwc_keyexp`

## Requirements
- R1: On load, the low 64 bits of the master key become k0 and the high 64 bits become k1; in encrypt mode the first key presented is k0.
- R2: In ascending order, k(i+2) = k(i) XOR C XOR z(i) XOR rotr(k(i+1),3) XOR rotr(k(i+1),4), where C is 64'hFFFF_FFFF_FFFF_FFFC and z(i) is XORed into bit 0.
- R3: z(i) is bit (i mod 62) of 62'b10101111011100000011010010011000101000010001111110010110110011, indexed 0 at the leftmost (most significant) digit; keys k64..k67 reuse the sequence from its start.
- R4: After an encrypt load, ready is high on the next cycle and each accepted advance moves the output to the next key, through k67.
- R5: After a decrypt load, ready stays low for exactly 66 cycles, rises on the 67th cycle after the load edge, and the first key presented is k67.
- R6: In decrypt mode each accepted advance moves the output down by one key, from k67 through k0.
- R7: An advance while ready is low (after reset or during the decrypt wind-up) has no effect on the keys produced afterwards.
- R8: An advance while the final key of the order (k67 for encrypt, k0 for decrypt) is shown is ignored, and that key stays on the output.
- R9: A load restarts the unit at any time, takes priority over a simultaneous advance, and may change direction.
- R10: After reset, ready is low until the first load.
- R11: While ready is high and neither load nor advance is asserted, the output key does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture master key and direction |
| key_i | input | 128 | Master key; high word k1, low word k0 |
| decrypt_i | input | 1 | Direction sampled at load: 1 gives descending keys |
| advance_i | input | 1 | Step to the next key of the chosen order |
| rkey_o | output | 64 | Current round key |
| ready_o | output | 1 | Round key valid and advances accepted |

## Verification
Every generated key is compared with a list of all 68 keys that the bench computes arithmetically. This is done for an all-zero key, an all-ones key, counting-byte and alternating patterns, and a sweep of single-bit keys across both words. The single-bit keys show whether each word and each bit lane reaches the right place through the rotations. The all-ones and all-zero keys expose the constant C and the z bit on their own. Keys k64..k67 show whether the sequence wraps at 62. Each key is run in both directions, so the forward and inverted recurrences are checked against the same list. The wind-up length is also checked in decrypt mode. Stray advances during wind-up, at the final key and at the same time as a new load show whether the end-of-order and priority rules hold.

// File: rtl/lwc_keyexp_pkg.sv
package lwc_keyexp_pkg;
   localparam int unsigned KX_WORD   = 64;
   localparam int unsigned KX_ROUNDS = 68;
   localparam int unsigned KX_ZLEN   = 62;
   localparam logic [KX_ZLEN-1:0] KX_ZSEQ =
      62'b10101111011100000011010010011000101000010001111110010110110011;

   typedef enum logic [1:0] {
      KX_IDLE = 2'd0,
      KX_WIND = 2'd1,
      KX_RUN  = 2'd2
   } kx_state_e;
endpackage

// File: rtl/lwc_kx_zseq.sv
module lwc_kx_zseq #(
   parameter int unsigned      ZLEN = 62,
   parameter logic [ZLEN-1:0]  ZSEQ = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic fwd_i,
   input  logic bwd_i,
   output logic z_cur_o,
   output logic z_prev_o
);
   localparam int unsigned IW = (ZLEN > 1) ? $clog2(ZLEN) : 1;
   localparam logic [IW-1:0] LAST = IW'(ZLEN - 1);

   generate
      if (ZLEN < 2) begin : g_bad_len
         $error("lwc_kx_zseq: ZLEN must be at least 2");
      end
   endgenerate

   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_prev;
   logic [IW-1:0] idx_next;

   assign idx_prev = (idx_q == '0)   ? LAST : idx_q - 1'b1;
   assign idx_next = (idx_q == LAST) ? '0   : idx_q + 1'b1;

   // index 0 is the leftmost digit of the sequence
   assign z_cur_o  = ZSEQ[LAST - idx_q];
   assign z_prev_o = ZSEQ[LAST - idx_prev];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (clear_i) idx_q <= '0;
      else if (fwd_i)   idx_q <= idx_next;
      else if (bwd_i)   idx_q <= idx_prev;
   end

   p_zidx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);
   p_zidx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> idx_q == '0);
endmodule

// File: rtl/lwc_kx_step.sv
module lwc_kx_step #(
   parameter int unsigned WORD  = 64,
   parameter int unsigned ROT_A = 3,
   parameter int unsigned ROT_B = 4
) (
   input  logic [WORD-1:0] lo_i,
   input  logic [WORD-1:0] hi_i,
   input  logic            z_fwd_i,
   input  logic            z_bwd_i,
   output logic [WORD-1:0] next_o,
   output logic [WORD-1:0] prev_o
);
   localparam logic [WORD-1:0] KCONST = {{(WORD-2){1'b1}}, 2'b00};

   generate
      if (ROT_A == 0 || ROT_A >= WORD || ROT_B == 0 || ROT_B >= WORD) begin : g_bad_rot
         $error("lwc_kx_step: rotation amounts must lie in 1..WORD-1");
      end
   endgenerate

   function automatic logic [WORD-1:0] rotr(input logic [WORD-1:0] x, input int unsigned s);
      return (x >> s) | (x << (WORD - s));
   endfunction

   function automatic logic [WORD-1:0] mix(input logic [WORD-1:0] a,
                                           input logic [WORD-1:0] b,
                                           input logic z);
      return a ^ KCONST ^ {{(WORD-1){1'b0}}, z} ^ rotr(b, ROT_A) ^ rotr(b, ROT_B);
   endfunction

   // ascending: (k_i, k_i+1) -> k_i+2 ; descending: (k_i+1, k_i+2) -> k_i
   assign next_o = mix(lo_i, hi_i, z_fwd_i);
   assign prev_o = mix(hi_i, lo_i, z_bwd_i);
endmodule

// File: rtl/lwc_keyexp.sv
module lwc_keyexp
   import lwc_keyexp_pkg::*;
#(
   parameter int unsigned              WORD      = KX_WORD,
   parameter int unsigned              KEY_WORDS = 2,
   parameter int unsigned              ROUNDS    = KX_ROUNDS,
   parameter int unsigned              ZLEN      = KX_ZLEN,
   parameter logic [KX_ZLEN-1:0]       ZSEQ      = KX_ZSEQ
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic [KEY_WORDS*WORD-1:0] key_i,
   input  logic                      decrypt_i,
   input  logic                      advance_i,
   output logic [WORD-1:0]           rkey_o,
   output logic                      ready_o
);
   localparam int unsigned CW        = $clog2(ROUNDS);
   localparam logic [CW-1:0] LAST_ADV = CW'(ROUNDS - 1);
   localparam logic [CW-1:0] LAST_WND = CW'(ROUNDS - 3);

   generate
      if (KEY_WORDS != 2) begin : g_bad_words
         $error("lwc_keyexp: only a two-word master key is supported");
      end
      if (ROUNDS < 4) begin : g_bad_rounds
         $error("lwc_keyexp: ROUNDS must be at least 4");
      end
      if (ZLEN != KX_ZLEN) begin : g_bad_zlen
         $error("lwc_keyexp: ZLEN must match the constant sequence length");
      end
   endgenerate

   kx_state_e       state_q;
   logic [WORD-1:0] lo_q, hi_q;
   logic [CW-1:0]   cnt_q;
   logic            dec_q;

   logic            at_end;
   logic            step_fwd, step_bwd;
   logic            z_cur, z_prev;
   logic [WORD-1:0] k_next, k_prev;

   assign at_end   = (cnt_q == LAST_ADV);
   assign step_fwd = !load_i && ((state_q == KX_WIND) ||
                     (state_q == KX_RUN && !dec_q && advance_i && !at_end));
   assign step_bwd = !load_i && state_q == KX_RUN && dec_q && advance_i && !at_end;

   lwc_kx_zseq #(.ZLEN(ZLEN), .ZSEQ(ZSEQ)) u_zseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (load_i),
      .fwd_i    (step_fwd),
      .bwd_i    (step_bwd),
      .z_cur_o  (z_cur),
      .z_prev_o (z_prev)
   );

   lwc_kx_step #(.WORD(WORD), .ROT_A(3), .ROT_B(4)) u_step (
      .lo_i    (lo_q),
      .hi_i    (hi_q),
      .z_fwd_i (z_cur),
      .z_bwd_i (z_prev),
      .next_o  (k_next),
      .prev_o  (k_prev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KX_IDLE;
         lo_q    <= '0;
         hi_q    <= '0;
         cnt_q   <= '0;
         dec_q   <= 1'b0;
      end else if (load_i) begin
         lo_q    <= key_i[WORD-1:0];
         hi_q    <= key_i[2*WORD-1:WORD];
         cnt_q   <= '0;
         dec_q   <= decrypt_i;
         state_q <= decrypt_i ? KX_WIND : KX_RUN;
      end else if (step_fwd) begin
         lo_q <= hi_q;
         hi_q <= k_next;
         if (state_q == KX_WIND) begin
            if (cnt_q == LAST_WND) begin
               cnt_q   <= '0;
               state_q <= KX_RUN;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (step_bwd) begin
         hi_q  <= lo_q;
         lo_q  <= k_prev;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready_o = (state_q == KX_RUN);
   assign rkey_o  = dec_q ? hi_q : lo_q;

   p_enc_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !decrypt_i |=> ready_o && rkey_o == $past(key_i[WORD-1:0]));
   p_fwd_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && !dec_q && advance_i && !load_i && !at_end |=> rkey_o == $past(hi_q));
   p_bwd_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && dec_q && advance_i && !load_i && !at_end |=> hi_q == $past(lo_q));
   p_dec_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && decrypt_i |=> !ready_o);
   p_wind_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == KX_WIND |-> cnt_q <= LAST_WND);
   p_end_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && at_end && !load_i |=> $stable(rkey_o) && ready_o);
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && !advance_i && !load_i |=> $stable(rkey_o) && ready_o);
   p_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == KX_IDLE && !load_i |=> !ready_o);
endmodule

// File: tb/lwc_keyexp_tb.sv
module lwc_keyexp_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NK = 68;
   localparam logic [63:0]  C64  = 64'hFFFF_FFFF_FFFF_FFFC;
   localparam logic [61:0]  ZREF = 62'b10101111011100000011010010011000101000010001111110010110110011;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [127:0] key_i = '0;
   logic         decrypt_i = 1'b0;
   logic         advance_i = 1'b0;
   logic [63:0]  rkey_o;
   logic         ready_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [63:0] exp_k [NK];

   always #(CLK_PERIOD/2) clk = ~clk;

   lwc_keyexp u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
      .decrypt_i(decrypt_i), .advance_i(advance_i),
      .rkey_o(rkey_o), .ready_o(ready_o)
   );

   function automatic logic [63:0] rr(input logic [63:0] x, input int s);
      return (x >> s) | (x << (64 - s));
   endfunction

   // R2/R3 reference: full ascending list
   task automatic build_ref(input logic [127:0] k);
      exp_k[0] = k[63:0];
      exp_k[1] = k[127:64];
      for (int i = 0; i < NK - 2; i++) begin
         logic zb;
         zb = ZREF[61 - (i % 62)];
         exp_k[i+2] = exp_k[i] ^ C64 ^ {63'd0, zb} ^ rr(exp_k[i+1], 3) ^ rr(exp_k[i+1], 4);
      end
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_enc(input logic [127:0] k, input bit stray_load);
      build_ref(k);
      @(negedge clk);
      key_i = k; decrypt_i = 1'b0; load_i = 1'b1; advance_i = stray_load;
      @(negedge clk);
      load_i = 1'b0; advance_i = 1'b0;
      chk(ready_o === 1'b1, "R4 ready after encrypt load", {63'd0, ready_o}, 64'd1);
      chk(rkey_o === exp_k[0], "R1 first key is low word", rkey_o, exp_k[0]);
      // R11: no advance, key holds
      @(negedge clk);
      chk(rkey_o === exp_k[0], "R11 key stable without advance", rkey_o, exp_k[0]);
      for (int i = 1; i < NK; i++) begin
         advance_i = 1'b1;
         @(negedge clk);
         chk(rkey_o === exp_k[i], (i == 1) ? "R1 second key is high word" :
             (i >= 64) ? "R3 key after constant wrap" : "R2 ascending key", rkey_o, exp_k[i]);
      end
      @(negedge clk);
      advance_i = 1'b0;
      chk(rkey_o === exp_k[NK-1], "R8 encrypt end holds k67", rkey_o, exp_k[NK-1]);
      chk(ready_o === 1'b1, "R8 ready stays high at end", {63'd0, ready_o}, 64'd1);
   endtask

   task automatic run_dec(input logic [127:0] k);
      build_ref(k);
      @(negedge clk);
      key_i = k; decrypt_i = 1'b1; load_i = 1'b1; advance_i = 1'b0;
      for (int w = 0; w < 66; w++) begin
         @(negedge clk);
         load_i = 1'b0;
         advance_i = (w % 3 == 0) && (w < 60);   // R7 stray advances while winding
         chk(ready_o === 1'b0, "R5 ready low during wind-up", {63'd0, ready_o}, 64'd0);
      end
      @(negedge clk);
      advance_i = 1'b0;
      chk(ready_o === 1'b1, "R5 ready on 67th cycle", {63'd0, ready_o}, 64'd1);
      chk(rkey_o === exp_k[NK-1], "R5 first decrypt key is k67", rkey_o, exp_k[NK-1]);
      for (int i = NK - 2; i >= 0; i--) begin
         advance_i = 1'b1;
         @(negedge clk);
         chk(rkey_o === exp_k[i], "R6 descending key", rkey_o, exp_k[i]);
      end
      @(negedge clk);
      advance_i = 1'b0;
      chk(rkey_o === exp_k[0], "R8 decrypt end holds k0", rkey_o, exp_k[0]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ready_o === 1'b0, "R10 ready low in reset", {63'd0, ready_o}, 64'd0);
      rst_n = 1'b1;
      // R7: advances before any load
      advance_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(ready_o === 1'b0, "R10 ready low before load", {63'd0, ready_o}, 64'd0);
      advance_i = 1'b0;

      run_enc(128'h0, 1'b0);
      run_dec(128'h0);
      run_enc({128{1'b1}}, 1'b0);
      run_dec({128{1'b1}});
      run_enc(128'h0f0e0d0c0b0a0908_0706050403020100, 1'b1);  // R9 load beats advance
      run_dec(128'h0f0e0d0c0b0a0908_0706050403020100);
      run_enc(128'haaaa5555aaaa5555_5555aaaa5555aaaa, 1'b0);
      run_dec(128'haaaa5555aaaa5555_5555aaaa5555aaaa);
      for (int b = 0; b < 128; b += 9) begin
         run_enc(128'd1 << b, 1'b0);
         run_dec(128'd1 << b);
      end

      // R9: restart in the middle of a decrypt order, switching to encrypt
      build_ref(128'h1234);
      @(negedge clk);
      key_i = 128'h1234; decrypt_i = 1'b1; load_i = 1'b1;
      repeat (70) begin
         @(negedge clk);
         load_i = 1'b0; advance_i = 1'b1;
      end
      key_i = 128'h5678_0000_0000_0000_0000_9abc; decrypt_i = 1'b0; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; advance_i = 1'b0;
      chk(rkey_o === 64'h9abc, "R9 reload mid-run gives new k0", rkey_o, 64'h9abc);
      chk(ready_o === 1'b1, "R9 reload ready", {63'd0, ready_o}, 64'd1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule